// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers up to 32 level-sensitive interrupt lines from on-chip peripherals and drives a single interrupt request toward a host processor. The host programs it through four word registers on a simple write/read bus. A configuration register carries a global enable and a promoted-source field. A mask register gates each line. An in-service register records the interrupts being handled. A vector register carries the acknowledge handshake.

To take an interrupt, the host writes the acknowledge bit of the vector register. At that clock edge the controller latches the number of the winning source and marks that source in service. The next read of the vector register returns the number in bits 15:11. While a source is in service, requests of equal or lower rank are held back from the processor. The host ends the interrupt by writing a one to the bit of that source in the in-service register. Vector number 0 is reserved as an error vector. It is returned when an acknowledge finds no eligible source, which is what happens when a source is masked or withdrawn between the request and the acknowledge.

Top module: `vpic_top`

## Requirements
- R1: After reset, all four registers (address 0 configuration, 1 mask, 2 in-service, 3 vector) read as zero and `irq` is low.
- R2: Mask register (address 1): bit k set enables source k and clear blocks it. A write changes the arbitration from the following clock on.
- R3: Configuration bit 7 is the global enable. While it is clear, `irq` stays low whatever the sources do.
- R4: Among eligible sources, the one with the higher vector number wins.
- R5: Configuration bits 17:13 name a promoted source that outranks all others. A value of 0 promotes nothing.
- R6: A write to address 3 with bit 0 set is an acknowledge. It latches the winning vector, which then reads back in bits 15:11 with all other bits zero. A write to address 3 with bit 0 clear changes nothing.
- R7: An acknowledge sets the in-service bit of the returned vector. A pending source drives `irq` only if its rank is strictly above that of every in-service source.
- R8: Writing a one to bit k of the in-service register (address 2) clears bit k. A zero bit leaves that bit unchanged.
- R9: An acknowledge that finds no eligible source returns vector 0 and sets in-service bit 0. Vector 0 ranks below every real source.
- R10: Source line 0 never raises `irq` and is never returned as a winner.
- R11: Sources are level sensitive: a source is pending exactly while its line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src | input | 32 | Level interrupt lines, bit index equals vector number |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| irq | output | 1 | Interrupt request to the host |

## Verification
Directed sequences drive several sources at once to show that the higher number wins. They then promote a low-numbered source to show that the promotion overrides the numeric order, with the field at zero as the no-promotion case. Nested acknowledges under a held in-service bit separate the strict-rank gating from plain priority. Acknowledges after masking a source or raising only line 0 must yield the error vector. A long run of random source levels and register writes is checked against a behavioural model every clock, which exposes ordering and write-one-clear slips that the directed cases miss.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  typedef enum logic [1:0] {
    A_CFG  = 2'd0,
    A_MASK = 2'd1,
    A_ISR  = 2'd2,
    A_VEC  = 2'd3
  } vpic_addr_e;

  localparam int CFG_GIE_BIT = 7;
  localparam int CFG_HP_LSB  = 13;
  localparam int VEC_LSB     = 11;
  localparam int ACK_BIT     = 0;

  // Rank of a vector: the promoted source (if non-zero) ranks above all.
  function automatic int prio_rank(int idx, int hp, int top);
    return (idx == hp && hp != 0) ? top : idx;
  endfunction
endpackage

// File: rtl/vpic_cfgmask.sv
module vpic_cfgmask
  import vpic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  localparam int VW    = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              gie_q,
  output logic [VW-1:0]     hp_q,
  output logic [NSRC-1:0]   mask_q
);
  logic            gie_d;
  logic [VW-1:0]   hp_d;
  logic [NSRC-1:0] mask_d;
  logic            cfg_en, mask_en;

  assign cfg_en  = wr_en && (addr == A_CFG);
  assign mask_en = wr_en && (addr == A_MASK);

  always_comb begin
    gie_d  = gie_q;
    hp_d   = hp_q;
    mask_d = mask_q;
    if (cfg_en) begin
      gie_d = wdata[CFG_GIE_BIT];
      hp_d  = wdata[CFG_HP_LSB +: VW];
    end
    if (mask_en) mask_d = wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      hp_q   <= '0;
      mask_q <= '0;
    end else begin
      if (cfg_en) begin
        gie_q <= gie_d;
        hp_q  <= hp_d;
      end
      if (mask_en) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/vpic_pick.sv
module vpic_pick
  import vpic_pkg::*;
#(
  parameter int NSRC = 32,
  localparam int VW  = $clog2(NSRC),
  localparam int RW  = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0] req,
  input  logic [VW-1:0]   hp,
  output logic            found,
  output logic [VW-1:0]   idx,
  output logic [RW-1:0]   rank
);
  logic [RW-1:0] r;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    rank  = '0;
    r     = '0;
    for (int i = 0; i < NSRC; i++) begin
      r = RW'(prio_rank(i, int'(hp), NSRC));
      if (req[i] && (!found || r > rank)) begin
        found = 1'b1;
        idx   = VW'(i);
        rank  = r;
      end
    end
  end
endmodule

// File: rtl/vpic_service.sv
module vpic_service #(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  localparam int VW    = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack,
  input  logic              isr_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              win_found,
  input  logic [VW-1:0]     win_idx,
  output logic [NSRC-1:0]   isr_q,
  output logic [VW-1:0]     vec_q
);
  logic [NSRC-1:0] isr_d;
  logic [VW-1:0]   vec_d;
  logic            isr_en;

  assign isr_en = ack || isr_wr;

  always_comb begin
    isr_d = isr_q;
    vec_d = vec_q;
    if (isr_wr) isr_d = isr_q & ~wdata[NSRC-1:0];
    if (ack) begin
      vec_d        = win_found ? win_idx : '0;
      isr_d[vec_d] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q <= '0;
      vec_q <= '0;
    end else begin
      if (isr_en) isr_q <= isr_d;
      if (ack)    vec_q <= vec_d;
    end
  end
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  localparam int VW    = $clog2(NSRC),
  localparam int RW    = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic            rst_meta, rst_sync;
  logic            gie_q;
  logic [VW-1:0]   hp_q;
  logic [NSRC-1:0] mask_q, isr_q, pend, elig;
  logic [VW-1:0]   vec_q, win_idx, isr_idx;
  logic [RW-1:0]   isr_rank, win_rank;
  logic            isr_found, win_found;
  logic            ack, isr_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign ack    = wr_en && (addr == A_VEC) && wdata[ACK_BIT];
  assign isr_wr = wr_en && (addr == A_ISR);

  vpic_cfgmask #(.NSRC(NSRC), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .gie_q(gie_q), .hp_q(hp_q), .mask_q(mask_q)
  );

  // Line 0 is reserved for the error vector.
  assign pend = src & mask_q & ~NSRC'(1);

  vpic_pick #(.NSRC(NSRC)) u_isr_pick (
    .req(isr_q), .hp(hp_q), .found(isr_found), .idx(isr_idx), .rank(isr_rank)
  );

  for (genvar g = 0; g < NSRC; g++) begin : g_elig
    assign elig[g] = pend[g] &&
                     (!isr_found || (RW'(prio_rank(g, int'(hp_q), NSRC)) > isr_rank));
  end

  vpic_pick #(.NSRC(NSRC)) u_win_pick (
    .req(elig), .hp(hp_q), .found(win_found), .idx(win_idx), .rank(win_rank)
  );

  vpic_service #(.NSRC(NSRC), .DATA_W(DATA_W)) u_svc (
    .clk(clk), .rst_n(rst_sync), .ack(ack), .isr_wr(isr_wr), .wdata(wdata),
    .win_found(win_found), .win_idx(win_idx), .isr_q(isr_q), .vec_q(vec_q)
  );

  assign irq = gie_q && win_found;

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CFG: begin
        rdata[CFG_GIE_BIT]       = gie_q;
        rdata[CFG_HP_LSB +: VW]  = hp_q;
      end
      A_MASK: rdata[NSRC-1:0]    = mask_q;
      A_ISR:  rdata[NSRC-1:0]    = isr_q;
      A_VEC:  rdata[VEC_LSB +: VW] = vec_q;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker
  import vpic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int DATA_W = 32,
  localparam int VW    = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst_sync,
  input logic              wr_en,
  input logic [1:0]        addr,
  input logic [DATA_W-1:0] wdata,
  input logic              gie_q,
  input logic              irq,
  input logic [NSRC-1:0]   mask_q,
  input logic [NSRC-1:0]   isr_q,
  input logic [VW-1:0]     vec_q,
  input logic              win_found,
  input logic [VW-1:0]     win_idx
);
  logic ack_c, isr_c, mask_c;
  assign ack_c  = wr_en && (addr == A_VEC) && wdata[ACK_BIT];
  assign isr_c  = wr_en && (addr == A_ISR);
  assign mask_c = wr_en && (addr == A_MASK);

  p_gie_gate_r3: assert property (@(posedge clk) disable iff (!rst_sync)
    !gie_q |-> !irq);

  p_mask_next_r2: assert property (@(posedge clk) disable iff (!rst_sync)
    mask_c |=> (mask_q == $past(wdata[NSRC-1:0])));

  p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_sync)
    ack_c |=> isr_q[vec_q]);

  p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    isr_c |=> ((isr_q & $past(wdata[NSRC-1:0])) == '0));

  p_err_vec_r9: assert property (@(posedge clk) disable iff (!rst_sync)
    (ack_c && !win_found) |=> (vec_q == '0));

  p_no_line0_r10: assert property (@(posedge clk) disable iff (!rst_sync)
    irq |-> (win_idx != '0));
endmodule

bind vpic_top vpic_checker #(.NSRC(NSRC), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_sync(rst_sync), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .gie_q(gie_q), .irq(irq), .mask_q(mask_q), .isr_q(isr_q), .vec_q(vec_q),
  .win_found(win_found), .win_idx(win_idx)
);

// File: tb/vpic_top_bench.sv
module vpic_top_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] src;
  logic        wr_en;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R1";

  // Reference state
  logic        m_gie;
  int          m_hp;
  logic [31:0] m_mask, m_isr;
  int          m_vec;

  vpic_top u_vpic_top (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic int rk(int i);
    return (i == m_hp && m_hp != 0) ? 32 : i;
  endfunction

  function automatic int top_isr();
    int t = -1;
    for (int i = 0; i < 32; i++) if (m_isr[i] && rk(i) > t) t = rk(i);
    return t;
  endfunction

  // Returns winning vector, or -1 when nothing is eligible.
  function automatic int winner();
    int t = top_isr();
    int best = -1;
    int br = -1;
    for (int i = 1; i < 32; i++)
      if (src[i] && m_mask[i] && rk(i) > t && rk(i) > br) begin
        best = i;
        br = rk(i);
      end
    return best;
  endfunction

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(logic wr, logic [1:0] a, logic [31:0] d);
    int w;
    @(negedge clk);
    check("irq", {31'b0, irq}, {31'b0, (m_gie && winner() >= 0)});
    wr_en = wr; addr = a; wdata = d;
    @(posedge clk);
    #1;
    if (wr) begin
      case (a)
        2'd0: begin m_gie = d[7]; m_hp = int'(d[17:13]); end
        2'd1: m_mask = d;
        2'd2: m_isr = m_isr & ~d;
        default: if (d[0]) begin
          w = winner();
          m_vec = (w < 0) ? 0 : w;
          m_isr[m_vec] = 1'b1;
        end
      endcase
    end
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a);
    logic [31:0] e;
    @(negedge clk);
    addr = a;
    #1;
    case (a)
      2'd0: e = (32'(m_gie) << 7) | (32'(m_hp) << 13);
      2'd1: e = m_mask;
      2'd2: e = m_isr;
      default: e = 32'(m_vec) << 11;
    endcase
    check($sformatf("read addr %0d", a), rdata, e);
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src = '0; wr_en = 1'b0; addr = '0; wdata = '0;
    m_gie = 1'b0; m_hp = 0; m_mask = '0; m_isr = '0; m_vec = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset state
    tag = "R1";
    for (int a = 0; a < 4; a++) rd(2'(a));
    cyc(1'b0, 2'd0, '0);

    // R2 / R3: mask and global enable
    tag = "R2";
    cyc(1'b1, 2'd1, 32'h0000_0010);
    rd(2'd1);
    src = 32'h0000_0010;
    tag = "R3";
    cyc(1'b0, 2'd0, '0);
    cyc(1'b1, 2'd0, 32'h80);
    cyc(1'b0, 2'd0, '0);
    rd(2'd0);

    // R4: fixed order
    tag = "R4";
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF);
    src = 32'h0010_0210;
    cyc(1'b0, 2'd0, '0);
    tag = "R6";
    cyc(1'b1, 2'd3, 32'h1);
    rd(2'd3);
    // R7: nesting under in-service
    tag = "R7";
    cyc(1'b0, 2'd0, '0);
    rd(2'd2);
    src = src | 32'h0200_0000;
    cyc(1'b0, 2'd0, '0);
    cyc(1'b1, 2'd3, 32'h1);
    rd(2'd3);
    // R8: write one clears, write zero keeps
    tag = "R8";
    cyc(1'b1, 2'd2, 32'h0200_0000);
    rd(2'd2);
    cyc(1'b1, 2'd2, 32'h0);
    rd(2'd2);
    cyc(1'b1, 2'd2, 32'h0010_0000);
    rd(2'd2);
    // R6: write without ack bit changes nothing
    tag = "R6";
    cyc(1'b1, 2'd3, 32'hFFFF_FFFE);
    rd(2'd3);
    rd(2'd2);

    // R5: promoted source
    tag = "R5";
    cyc(1'b1, 2'd0, 32'h80 | (32'd4 << 13));
    rd(2'd0);
    cyc(1'b1, 2'd3, 32'h1);
    rd(2'd3);
    cyc(1'b1, 2'd2, 32'hFFFF_FFFF);
    cyc(1'b1, 2'd0, 32'h80);

    // R9: masked between request and acknowledge
    tag = "R9";
    src = 32'h0000_0200;
    cyc(1'b1, 2'd1, 32'h0);
    cyc(1'b1, 2'd3, 32'h1);
    rd(2'd3);
    rd(2'd2);
    cyc(1'b1, 2'd2, 32'h1);
    rd(2'd2);

    // R10: line 0 alone
    tag = "R10";
    cyc(1'b1, 2'd1, 32'hFFFF_FFFF);
    src = 32'h1;
    cyc(1'b0, 2'd0, '0);
    cyc(1'b1, 2'd3, 32'h1);
    rd(2'd3);
    cyc(1'b1, 2'd2, 32'hFFFF_FFFF);

    // R11: level sensitivity
    tag = "R11";
    src = 32'h0000_0200;
    cyc(1'b0, 2'd0, '0);
    src = 32'h0;
    cyc(1'b0, 2'd0, '0);

    // Random mix, compared every clock
    tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      int op;
      logic [31:0] d;
      op  = int'($urandom_range(0, 9));
      d   = $urandom;
      src = $urandom & $urandom;
      case (op)
        0: cyc(1'b1, 2'd0, (d & 32'h0003_E000) | 32'h80);
        1: cyc(1'b1, 2'd1, d | $urandom);
        2, 3: cyc(1'b1, 2'd2, d & $urandom);
        4, 5: cyc(1'b1, 2'd3, 32'h1);
        6: rd(2'(d[1:0]));
        default: cyc(1'b0, 2'd0, '0);
      endcase
      if (op == 4) rd(2'd3);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule